// File: doc/BRIEF.md
# Trap Entry Controller

This block computes every architectural update a hart makes when it enters a trap, whether the trap is a synchronous exception or an interrupt. The pipeline presents a single-cycle request together with the trap kind, a raw cause code, the faulting address, the PC of the trapping instruction, the current privilege level, the status word, the two delegation masks and the two vector bases. One cycle later the block presents the next PC, the next privilege level and the next status word. It also presents write strobes, with shared data buses, for the cause, exception-PC and bad-address registers of whichever mode takes the trap.

Before delegation is decided, the raw cause is resolved. Translation failures become page faults or access faults depending on whether paging is on. Environment calls are renumbered by the privilege they came from. Interrupts carry the top bit of the cause word. The resolved code then selects a bit of the exception mask or of the interrupt mask. A trap from user or supervisor level whose bit is set goes to supervisor mode. Every other trap goes to machine mode.

A two-state sequencer governs acceptance. `ST_IDLE` moves to `ST_COMMIT` when a request arrives and stays put otherwise. `ST_COMMIT` always returns to `ST_IDLE` on the next edge. While in `ST_COMMIT` the block is busy, and a request in that cycle is dropped.

Top module: `trap_entry_ctrl`

## Requirements
- R1: During and right after reset, `done` and `busy` are 0 and all six write strobes are 0.
- R2: A request accepted in `ST_IDLE` makes `done` and `busy` 1 for exactly the next cycle, with every result output valid in that cycle. A request arriving while `busy` is 1 is ignored: the cycle after it shows `done` = 0 and no strobe.
- R3: For an interrupt, `cause_val` has bit XLEN-1 set, `trap_code` in its low bits and zeros elsewhere. `xlat_fail` is ignored for interrupts.
- R4: An exception with code 8 (environment call) is reported as 8 plus the privilege encoding: 8 from user (0), 9 from supervisor (1), 11 from machine (3).
- R5: An exception with `xlat_fail` = 1 ignores `trap_code`. With `xlat_kind` 0 (fetch), 1 (load) or 2/3 (store), it reports 12/13/15 when `paging_on` is 1 and 1/5/7 when it is 0.
- R6: The delegation bit is `irq_deleg[trap_code]` for interrupts and `exc_deleg[resolved code]` for exceptions. The trap targets supervisor (priv 1) only when `cur_priv` is 0 or 1 and that bit is set. Otherwise it targets machine (priv 3), including from priv 2 and priv 3.
- R7: Supervisor entry sets `next_pc` = `s_vec` with bits 1:0 cleared and `next_priv` = 1, and asserts `wr_s_cause` and `wr_s_epc`. `epc_val` = `cur_pc`. Status bit 5 takes old bit 1, bit 8 takes `cur_priv[0]`, bit 1 is cleared, and all other bits are unchanged.
- R8: Machine entry sets `next_pc` = `m_vec` with bits 1:0 cleared and `next_priv` = 3, and asserts `wr_m_cause` and `wr_m_epc`. Status bit 7 takes old bit 3, bits 12:11 take `cur_priv`, bit 3 is cleared, and all other bits are unchanged.
- R9: The target mode's bad-address strobe is asserted, with `tval_val` = `fault_addr`, only for exceptions whose resolved code is 0, 1, 4, 5, 6, 7, 12, 13 or 15. It is never asserted for an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Trap request strobe |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CODE_W | Raw cause code or interrupt number |
| xlat_fail | input | 1 | Exception is an address translation failure |
| xlat_kind | input | 2 | Access kind of the failure: 0 fetch, 1 load, 2/3 store |
| paging_on | input | 1 | Paging is active |
| fault_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| status_in | input | XLEN | Current status word |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| s_vec | input | XLEN | Supervisor vector base |
| m_vec | input | XLEN | Machine vector base |
| busy | output | 1 | Commit cycle in progress; new requests are dropped |
| done | output | 1 | Results valid this cycle |
| next_pc | output | XLEN | Handler PC |
| next_priv | output | 2 | Privilege after entry |
| next_status | output | XLEN | Status word after entry |
| cause_val | output | XLEN | Data for the cause register |
| epc_val | output | XLEN | Data for the exception-PC register |
| tval_val | output | XLEN | Data for the bad-address register |
| wr_s_cause | output | 1 | Write supervisor cause |
| wr_s_epc | output | 1 | Write supervisor exception PC |
| wr_s_tval | output | 1 | Write supervisor bad address |
| wr_m_cause | output | 1 | Write machine cause |
| wr_m_epc | output | 1 | Write machine exception PC |
| wr_m_tval | output | 1 | Write machine bad address |

## Verification
The hardest situation to reach from the ports is a second request that lands exactly in the `ST_COMMIT` cycle. The bench holds `trap_req` high for three consecutive cycles and changes the inputs between them. It then expects `done` to read 1, 0, 1, with the third cycle reporting the new trap. Delegation that must be refused is the other subtle case: machine and reserved privilege with the mask bit set. To catch a wrong bit index or the wrong mask, each table vector sets either only the relevant bit or every bit except it. The opposite mask always gets the complementary pattern.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } seq_e;

    // status word bit positions decoded by neighbouring logic
    localparam int SB_SIE    = 1;
    localparam int SB_MIE    = 3;
    localparam int SB_SPIE   = 5;
    localparam int SB_MPIE   = 7;
    localparam int SB_SPP    = 8;
    localparam int SB_MPP_LO = 11;

    // resolved exception codes
    localparam int EC_FETCH_MISAL = 0;
    localparam int EC_FETCH_ACC   = 1;
    localparam int EC_LOAD_MISAL  = 4;
    localparam int EC_LOAD_ACC    = 5;
    localparam int EC_STORE_MISAL = 6;
    localparam int EC_STORE_ACC   = 7;
    localparam int EC_ENV_BASE    = 8;
    localparam int EC_FETCH_PF    = 12;
    localparam int EC_LOAD_PF     = 13;
    localparam int EC_STORE_PF    = 15;

endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              xlat_fail,
    input  logic [1:0]        xlat_kind,
    input  logic              paging_on,
    input  logic [1:0]        cur_priv,
    output logic [CODE_W-1:0] eff_code,
    output logic [XLEN-1:0]   cause_word,
    output logic              need_tval
);
    localparam int NCODES = 2 ** CODE_W;

    function automatic logic [NCODES-1:0] tval_codes_f();
        logic [NCODES-1:0] m;
        m = '0;
        m[EC_FETCH_MISAL] = 1'b1;
        m[EC_FETCH_ACC]   = 1'b1;
        m[EC_LOAD_MISAL]  = 1'b1;
        m[EC_LOAD_ACC]    = 1'b1;
        m[EC_STORE_MISAL] = 1'b1;
        m[EC_STORE_ACC]   = 1'b1;
        m[EC_FETCH_PF]    = 1'b1;
        m[EC_LOAD_PF]     = 1'b1;
        m[EC_STORE_PF]    = 1'b1;
        return m;
    endfunction

    localparam logic [NCODES-1:0] TVAL_CODES = tval_codes_f();

    logic [CODE_W-1:0] xlat_code;

    always_comb begin
        unique case (xlat_kind)
            2'd0:    xlat_code = paging_on ? CODE_W'(EC_FETCH_PF) : CODE_W'(EC_FETCH_ACC);
            2'd1:    xlat_code = paging_on ? CODE_W'(EC_LOAD_PF)  : CODE_W'(EC_LOAD_ACC);
            default: xlat_code = paging_on ? CODE_W'(EC_STORE_PF) : CODE_W'(EC_STORE_ACC);
        endcase
    end

    always_comb begin
        if (irq) begin
            eff_code = raw_code;
        end else if (xlat_fail) begin
            eff_code = xlat_code;
        end else if (raw_code == CODE_W'(EC_ENV_BASE)) begin
            eff_code = CODE_W'(EC_ENV_BASE) + CODE_W'(cur_priv);
        end else begin
            eff_code = raw_code;
        end
    end

    always_comb begin
        cause_word               = '0;
        cause_word[CODE_W-1:0]   = eff_code;
        cause_word[XLEN-1]       = irq;
    end

    assign need_tval = !irq && TVAL_CODES[eff_code];

endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] eff_code,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    output logic              to_super
);
    logic [XLEN-1:0] mask;
    logic            low_priv;

    assign mask     = irq ? irq_deleg : exc_deleg;
    assign low_priv = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);
    assign to_super = low_priv && mask[eff_code];

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status_in,
    input  logic [1:0]      cur_priv,
    input  logic            to_super,
    output logic [XLEN-1:0] status_out
);
    always_comb begin
        status_out = status_in;
        if (to_super) begin
            status_out[SB_SPIE] = status_in[SB_SIE];
            status_out[SB_SPP]  = cur_priv[0];
            status_out[SB_SIE]  = 1'b0;
        end else begin
            status_out[SB_MPIE]              = status_in[SB_MIE];
            status_out[SB_MPP_LO+1:SB_MPP_LO] = cur_priv;
            status_out[SB_MIE]               = 1'b0;
        end
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter  int XLEN   = 32,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic              xlat_fail,
    input  logic [1:0]        xlat_kind,
    input  logic              paging_on,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   status_in,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    input  logic [XLEN-1:0]   s_vec,
    input  logic [XLEN-1:0]   m_vec,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   next_pc,
    output logic [1:0]        next_priv,
    output logic [XLEN-1:0]   next_status,
    output logic [XLEN-1:0]   cause_val,
    output logic [XLEN-1:0]   epc_val,
    output logic [XLEN-1:0]   tval_val,
    output logic              wr_s_cause,
    output logic              wr_s_epc,
    output logic              wr_s_tval,
    output logic              wr_m_cause,
    output logic              wr_m_epc,
    output logic              wr_m_tval
);
    localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);

    seq_e              state_q, state_d;
    logic              accept;
    logic [CODE_W-1:0] eff_code;
    logic [XLEN-1:0]   cause_word;
    logic              need_tval;
    logic              to_super;
    logic [XLEN-1:0]   status_new;

    trap_cause_fix #(.XLEN(XLEN), .CODE_W(CODE_W)) u_cause (
        .irq        (trap_irq),
        .raw_code   (trap_code),
        .xlat_fail  (xlat_fail),
        .xlat_kind  (xlat_kind),
        .paging_on  (paging_on),
        .cur_priv   (cur_priv),
        .eff_code   (eff_code),
        .cause_word (cause_word),
        .need_tval  (need_tval)
    );

    trap_deleg_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_deleg (
        .irq       (trap_irq),
        .eff_code  (eff_code),
        .cur_priv  (cur_priv),
        .exc_deleg (exc_deleg),
        .irq_deleg (irq_deleg),
        .to_super  (to_super)
    );

    trap_status_upd #(.XLEN(XLEN)) u_status (
        .status_in  (status_in),
        .cur_priv   (cur_priv),
        .to_super   (to_super),
        .status_out (status_new)
    );

    assign accept = trap_req && (state_q == ST_IDLE);

    // sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (trap_req) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy = (state_q == ST_COMMIT);

    // result register, loaded on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done        <= 1'b0;
            next_pc     <= '0;
            next_priv   <= PRIV_M;
            next_status <= '0;
            cause_val   <= '0;
            epc_val     <= '0;
            tval_val    <= '0;
            wr_s_cause  <= 1'b0;
            wr_s_epc    <= 1'b0;
            wr_s_tval   <= 1'b0;
            wr_m_cause  <= 1'b0;
            wr_m_epc    <= 1'b0;
            wr_m_tval   <= 1'b0;
        end else begin
            done       <= accept;
            wr_s_cause <= accept && to_super;
            wr_s_epc   <= accept && to_super;
            wr_s_tval  <= accept && to_super && need_tval;
            wr_m_cause <= accept && !to_super;
            wr_m_epc   <= accept && !to_super;
            wr_m_tval  <= accept && !to_super && need_tval;
            if (accept) begin
                next_pc     <= (to_super ? s_vec : m_vec) & VEC_MASK;
                next_priv   <= to_super ? PRIV_S : PRIV_M;
                next_status <= status_new;
                cause_val   <= cause_word;
                epc_val     <= cur_pc;
                tval_val    <= fault_addr;
            end
        end
    end

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(wr_s_cause || wr_s_epc || wr_s_tval || wr_m_cause || wr_m_epc || wr_m_tval));

    a_r2_accept_done: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !busy) |=> (done && busy));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trap_req) |=> !done);

    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_s_cause != wr_m_cause));

    a_r6_machine_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !busy && cur_priv == PRIV_M) |=> (wr_m_cause && !wr_s_cause));

    a_r7_super_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_s_cause) |-> (next_priv == PRIV_S && wr_s_epc && !next_status[SB_SIE]
                                  && next_pc[1:0] == 2'b00));

    a_r8_machine_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_m_cause) |-> (next_priv == PRIV_M && wr_m_epc && !next_status[SB_MIE]
                                  && next_pc[1:0] == 2'b00));

    a_r9_no_tval_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cause_val[XLEN-1]) |-> !(wr_s_tval || wr_m_tval));

endmodule

// File: tb/sim_trap_entry_ctrl.sv
module sim_trap_entry_ctrl;
    localparam int XLEN = 32;
    localparam int CW   = 5;
    localparam int NV   = 21;

    // {irq, code[5], xf, kind[2], pg, priv[2], dg, exp_code[5], exp_s, exp_tval}
    localparam logic [19:0] TBL [NV] = '{
        {1'b0, 5'd2,  1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 5'd2,  1'b1, 1'b0},
        {1'b0, 5'd2,  1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd2,  1'b0, 1'b0},
        {1'b0, 5'd8,  1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 5'd8,  1'b1, 1'b0},
        {1'b0, 5'd8,  1'b0, 2'd0, 1'b0, 2'd1, 1'b1, 5'd9,  1'b1, 1'b0},
        {1'b0, 5'd8,  1'b0, 2'd0, 1'b0, 2'd3, 1'b1, 5'd11, 1'b0, 1'b0},
        {1'b0, 5'd3,  1'b1, 2'd0, 1'b1, 2'd1, 1'b1, 5'd12, 1'b1, 1'b1},
        {1'b0, 5'd3,  1'b1, 2'd1, 1'b1, 2'd0, 1'b0, 5'd13, 1'b0, 1'b1},
        {1'b0, 5'd8,  1'b1, 2'd2, 1'b1, 2'd1, 1'b1, 5'd15, 1'b1, 1'b1},
        {1'b0, 5'd2,  1'b1, 2'd0, 1'b0, 2'd3, 1'b1, 5'd1,  1'b0, 1'b1},
        {1'b0, 5'd2,  1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 5'd5,  1'b1, 1'b1},
        {1'b0, 5'd2,  1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 5'd7,  1'b0, 1'b1},
        {1'b0, 5'd0,  1'b0, 2'd0, 1'b0, 2'd1, 1'b1, 5'd0,  1'b1, 1'b1},
        {1'b0, 5'd4,  1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd4,  1'b0, 1'b1},
        {1'b0, 5'd6,  1'b0, 2'd0, 1'b0, 2'd3, 1'b1, 5'd6,  1'b0, 1'b1},
        {1'b0, 5'd3,  1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 5'd3,  1'b1, 1'b0},
        {1'b1, 5'd5,  1'b0, 2'd0, 1'b0, 2'd1, 1'b1, 5'd5,  1'b1, 1'b0},
        {1'b1, 5'd7,  1'b0, 2'd0, 1'b0, 2'd3, 1'b1, 5'd7,  1'b0, 1'b0},
        {1'b1, 5'd9,  1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd9,  1'b0, 1'b0},
        {1'b0, 5'd2,  1'b0, 2'd0, 1'b0, 2'd2, 1'b1, 5'd2,  1'b0, 1'b0},
        {1'b0, 5'd13, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0, 5'd13, 1'b0, 1'b1},
        {1'b1, 5'd13, 1'b1, 2'd1, 1'b1, 2'd0, 1'b1, 5'd13, 1'b1, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            trap_req, trap_irq, xlat_fail, paging_on;
    logic [CW-1:0]   trap_code;
    logic [1:0]      xlat_kind, cur_priv;
    logic [XLEN-1:0] fault_addr, cur_pc, status_in, exc_deleg, irq_deleg, s_vec, m_vec;
    logic            busy, done;
    logic [XLEN-1:0] next_pc, next_status, cause_val, epc_val, tval_val;
    logic [1:0]      next_priv;
    logic            wr_s_cause, wr_s_epc, wr_s_tval, wr_m_cause, wr_m_epc, wr_m_tval;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_code(trap_code), .xlat_fail(xlat_fail), .xlat_kind(xlat_kind),
        .paging_on(paging_on), .fault_addr(fault_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .status_in(status_in), .exc_deleg(exc_deleg),
        .irq_deleg(irq_deleg), .s_vec(s_vec), .m_vec(m_vec), .busy(busy),
        .done(done), .next_pc(next_pc), .next_priv(next_priv),
        .next_status(next_status), .cause_val(cause_val), .epc_val(epc_val),
        .tval_val(tval_val), .wr_s_cause(wr_s_cause), .wr_s_epc(wr_s_epc),
        .wr_s_tval(wr_s_tval), .wr_m_cause(wr_m_cause), .wr_m_epc(wr_m_epc),
        .wr_m_tval(wr_m_tval)
    );

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] strobes();
        return {wr_s_cause, wr_s_epc, wr_s_tval, wr_m_cause, wr_m_epc, wr_m_tval};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; trap_irq = 1'b0; trap_code = '0;
        xlat_fail = 1'b0; xlat_kind = 2'd0; paging_on = 1'b0; fault_addr = '0;
        cur_pc = '0; cur_priv = 2'd3; status_in = '0; exc_deleg = '0;
        irq_deleg = '0; s_vec = '0; m_vec = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 32'(done), 32'd0);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 strobes after reset", 32'(strobes()), 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [19:0]     t;
            logic [CW-1:0]   idx;
            logic [XLEN-1:0] mask, st, es, ecause, epc_exp, exp_pc;
            logic [5:0]      estb;
            string           ctag;
            t = TBL[i];
            @(negedge clk);
            trap_irq   = t[19];
            trap_code  = t[18:14];
            xlat_fail  = t[13];
            xlat_kind  = t[12:11];
            paging_on  = t[10];
            cur_priv   = t[9:8];
            idx  = t[19] ? t[18:14] : t[6:2];
            mask = 32'h1 << idx;
            if (!t[7]) mask = ~mask;
            if (t[19]) begin
                irq_deleg = mask; exc_deleg = ~mask;
            end else begin
                exc_deleg = mask; irq_deleg = ~mask;
            end
            st         = 32'h5A5A_A5A5 ^ (i * 32'h0101_0F0F);
            status_in  = st;
            cur_pc     = 32'h1000_0000 + 32'(i * 4);
            fault_addr = 32'hDEAD_0000 | 32'(i);
            s_vec      = 32'h0000_4003 + 32'(i << 8);
            m_vec      = 32'h0000_8001 + 32'(i << 8);
            epc_exp    = cur_pc;
            trap_req   = 1'b1;
            @(negedge clk);
            trap_req   = 1'b0;

            es = st;
            if (t[1]) begin
                es[5] = st[1]; es[8] = t[8]; es[1] = 1'b0;
                exp_pc = s_vec & ~32'h3;
                estb = {1'b1, 1'b1, t[0], 3'b000};
            end else begin
                es[7] = st[3]; es[12:11] = t[9:8]; es[3] = 1'b0;
                exp_pc = m_vec & ~32'h3;
                estb = {3'b000, 1'b1, 1'b1, t[0]};
            end
            ecause = t[19] ? {1'b1, 26'd0, t[18:14]} : {27'd0, t[6:2]};
            if (t[19])                 ctag = "R3 interrupt cause";
            else if (t[13])            ctag = "R5 translation cause";
            else if (t[18:14] == 5'd8) ctag = "R4 ecall cause";
            else                       ctag = "R6 plain cause";

            chk("R2 done", 32'(done), 32'd1);
            chk("R2 busy", 32'(busy), 32'd1);
            chk(ctag, cause_val, ecause);
            chk("R6 target priv", 32'(next_priv), t[1] ? 32'd1 : 32'd3);
            chk("R9 strobes", 32'(strobes()), 32'(estb));
            chk(t[1] ? "R7 pc" : "R8 pc", next_pc, exp_pc);
            chk(t[1] ? "R7 status" : "R8 status", next_status, es);
            chk(t[1] ? "R7 epc" : "R8 epc", epc_val, epc_exp);
            if (t[0]) chk("R9 tval data", tval_val, 32'hDEAD_0000 | 32'(i));
            @(negedge clk);
            chk("R2 done drops", 32'(done), 32'd0);
        end

        // R2: request held for three cycles, middle one ignored
        @(negedge clk);
        trap_irq = 1'b0; trap_code = 5'd2; xlat_fail = 1'b0; cur_priv = 2'd0;
        exc_deleg = '0; irq_deleg = '0; trap_req = 1'b1;
        @(negedge clk);
        chk("R2 first done", 32'(done), 32'd1);
        chk("R2 first cause", cause_val, 32'd2);
        trap_code = 5'd8; cur_priv = 2'd1; exc_deleg = 32'h0000_0200;
        @(negedge clk);
        chk("R2 holdoff done", 32'(done), 32'd0);
        chk("R2 holdoff strobes", 32'(strobes()), 32'd0);
        chk("R2 holdoff busy", 32'(busy), 32'd0);
        @(negedge clk);
        trap_req = 1'b0;
        chk("R2 third done", 32'(done), 32'd1);
        chk("R4 third cause", cause_val, 32'd9);
        chk("R6 third target", 32'(next_priv), 32'd1);
        @(negedge clk);
        chk("R2 final idle", 32'(done), 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule